// File: doc/BRIEF.md
# Page Permission and Reference/Change Unit

This block sits at the end of a page-table walk. It receives one leaf translation entry with the address the entry was read from, plus the context of the access: whether it is a load, a store or an instruction fetch, whether the processor is in problem (user) state, whether the check is process-scoped or partition-scoped, and a three-bit authority-mask permission set. It decides whether the access may proceed. It reports the granted read/write/execute set or a fault cause word.

When the access is allowed, the block builds the updated entry. The referenced bit is always set in it, and the changed bit is set when the access is a store. The updated entry is written back to memory through a valid/ready port, and only when it differs from the entry that came in. A load or fetch never receives write permission. A later store to the same page therefore has to come back through the unit, and that pass sets the changed bit.

Requests are accepted one at a time with `req_valid`/`req_ready`. The result appears with a one-cycle `done` pulse. That pulse comes after the write-back handshake has completed, or after the unit has decided that no write-back is needed.

Top module: `perm_rc_unit`

## Requirements
- R1: A fetch (`req_acc`=2'b10) from an entry whose attribute field (bits [5:4]) equals 2'b10 (non-idempotent I/O) faults with only the guard cause bit (bit 28) set in `cause`. It grants nothing and issues no write-back.
- R2: For a process-scoped check (`req_part`=0) of an entry whose privileged bit (bit 3) is set, made in problem state (`req_prob`=1), the available permission set is empty. Any access then faults with a protection cause.
- R3: For a process-scoped check in supervisor state (`req_prob`=0) of a non-privileged entry, the available permissions are the entry's permission bits (bit 2 read, bit 1 write, bit 0 execute) ANDed bitwise with `req_amr`, which uses the same bit order.
- R4: In every case not covered by R2 or R3, the entry's permission bits are used alone and `req_amr` has no effect. This covers partition-scoped checks, privileged pages in supervisor state, and non-privileged pages in problem state.
- R5: If the permission required by the access is not available, `fault` is 1 and `cause` has the protection bit (bit 27) set. A load (2'b00, and also 2'b11) needs read, a store (2'b01) needs write, and a fetch needs execute. On any fault `grant` is 3'b000, and on success `cause` is 0.
- R6: On success the updated entry has the referenced bit (bit 8) set. It has the changed bit (bit 7) set only for a store. All other bits are copied from the input entry.
- R7: On a successful load or fetch, `grant` is the available set with the write bit cleared. On a successful store it is the full available set.
- R8: A write-back of the updated entry to `req_addr` is issued only on success and only when the updated entry differs from the input entry.
- R9: A store that faults with a protection cause also has the is-store bit (bit 25) set in `cause`. Loads and fetches never set it.
- R10: `wb_data` and `wb_addr` hold steady while `wb_valid` waits for `wb_ready`. `done` pulses for one cycle, two cycles after the request is accepted when there is no write-back, or one cycle after the write-back handshake. `wb_valid` is low while `done` is high.
- R11: `req_ready` is high only while the unit is idle. Out of reset it is high, and `done` and `wb_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| req_entry | input | ENTRY_W | Leaf translation entry |
| req_addr | input | ADDR_W | Memory address of the entry |
| req_acc | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 load |
| req_prob | input | 1 | Problem-state flag |
| req_part | input | 1 | 1 = partition-scoped check, 0 = process-scoped |
| req_amr | input | 3 | Authority-mask permissions {read, write, execute} |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Access denied |
| cause | output | CAUSE_W | Fault cause word |
| grant | output | 3 | Granted {read, write, execute} |
| wb_valid | output | 1 | Write-back request |
| wb_ready | input | 1 | Write-back accepted |
| wb_addr | output | ADDR_W | Write-back address |
| wb_data | output | ENTRY_W | Updated entry |

## Verification
A wrong permission decision shows on `grant`, `fault` and `cause` in the very `done` cycle of the request that triggered it. A wrong reference/change update shows earlier, on `wb_data` as soon as `wb_valid` rises. It can also show as a missing or spurious write-back for that request. A broken handshake or sequencing state shows as a `done` pulse arriving at the wrong cycle count after acceptance, or as `wb_data` moving while the write-back is stalled. Each of these is visible within a few cycles of the request.

// File: rtl/perm_rc_pkg.sv
package perm_rc_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_ALT   = 2'b11
  } acc_e;

  // permission vector order: [2] read, [1] write, [0] execute
  localparam int PB_RD = 2;
  localparam int PB_WR = 1;
  localparam int PB_EX = 0;
  localparam int NPERM = 3;

  // entry field positions
  localparam int EB_PERM_LO = 0;
  localparam int EB_PRIV    = 3;
  localparam int EB_ATT_LO  = 4;
  localparam int EB_ATT_HI  = 5;
  localparam int EB_CHG     = 7;
  localparam int EB_REF     = 8;
  localparam logic [1:0] ATT_NONIDEM_IO = 2'b10;

  // cause word bit positions
  localparam int CB_GUARD = 28;
  localparam int CB_PROT  = 27;
  localparam int CB_STORE = 25;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_EVAL = 2'b01,
    ST_WB   = 2'b10
  } st_e;

endpackage

// File: rtl/perm_eval.sv
module perm_eval
  import perm_rc_pkg::*;
#(
  parameter int ENTRY_W = 64,
  parameter int CAUSE_W = 32
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic [1:0]         acc,
  input  logic               prob,
  input  logic               part,
  input  logic [NPERM-1:0]   amr,
  output logic [NPERM-1:0]   grant,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause
);

  logic [NPERM-1:0] enc;
  logic [NPERM-1:0] mask;
  logic [NPERM-1:0] avail;
  logic [NPERM-1:0] need;
  logic             priv;
  logic             io_fetch;
  logic             use_amr;
  logic             deny_all;
  logic             prot;
  logic             is_store;

  assign enc      = entry[EB_PERM_LO +: NPERM];
  assign priv     = entry[EB_PRIV];
  assign is_store = (acc == ACC_STORE);
  assign io_fetch = (entry[EB_ATT_HI:EB_ATT_LO] == ATT_NONIDEM_IO) && (acc == ACC_FETCH);
  assign deny_all = !part && priv && prob;
  assign use_amr  = !part && !priv && !prob;

  // per-bit authority-mask gating
  for (genvar g = 0; g < NPERM; g++) begin : g_mask
    assign mask[g]  = use_amr ? amr[g] : 1'b1;
    assign avail[g] = !deny_all && enc[g] && mask[g];
  end

  always_comb begin
    need = '0;
    unique case (acc)
      ACC_STORE: need[PB_WR] = 1'b1;
      ACC_FETCH: need[PB_EX] = 1'b1;
      default:   need[PB_RD] = 1'b1;
    endcase
  end

  assign prot  = |(need & ~avail);
  assign fault = io_fetch || prot;

  always_comb begin
    cause = '0;
    if (io_fetch) begin
      cause[CB_GUARD] = 1'b1;
    end else if (prot) begin
      cause[CB_PROT]  = 1'b1;
      cause[CB_STORE] = is_store;
    end
  end

  always_comb begin
    grant = avail;
    if (!is_store) grant[PB_WR] = 1'b0;
    if (fault)     grant = '0;
  end

endmodule

// File: rtl/rc_update.sv
module rc_update
  import perm_rc_pkg::*;
#(
  parameter int ENTRY_W = 64
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic [1:0]         acc,
  output logic [ENTRY_W-1:0] upd,
  output logic               changed
);

  always_comb begin
    upd          = entry;
    upd[EB_REF]  = 1'b1;
    if (acc == ACC_STORE) upd[EB_CHG] = 1'b1;
  end

  assign changed = (upd != entry);

endmodule

// File: rtl/perm_rc_unit.sv
module perm_rc_unit
  import perm_rc_pkg::*;
#(
  parameter int ENTRY_W = 64,
  parameter int ADDR_W  = 48,
  parameter int CAUSE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ENTRY_W-1:0] req_entry,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_acc,
  input  logic               req_prob,
  input  logic               req_part,
  input  logic [2:0]         req_amr,
  output logic               done,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause,
  output logic [2:0]         grant,
  output logic               wb_valid,
  input  logic               wb_ready,
  output logic [ADDR_W-1:0]  wb_addr,
  output logic [ENTRY_W-1:0] wb_data
);

  st_e                state_q;
  logic [ENTRY_W-1:0] entry_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [1:0]         acc_q;
  logic               prob_q;
  logic               part_q;
  logic [NPERM-1:0]   amr_q;

  logic [NPERM-1:0]   ev_grant;
  logic               ev_fault;
  logic [CAUSE_W-1:0] ev_cause;
  logic [ENTRY_W-1:0] ev_upd;
  logic               ev_changed;

  assign req_ready = (state_q == ST_IDLE);

  perm_eval #(.ENTRY_W(ENTRY_W), .CAUSE_W(CAUSE_W)) u_eval (
    .entry (entry_q),
    .acc   (acc_q),
    .prob  (prob_q),
    .part  (part_q),
    .amr   (amr_q),
    .grant (ev_grant),
    .fault (ev_fault),
    .cause (ev_cause)
  );

  rc_update #(.ENTRY_W(ENTRY_W)) u_rc (
    .entry   (entry_q),
    .acc     (acc_q),
    .upd     (ev_upd),
    .changed (ev_changed)
  );

  // request capture
  always_ff @(posedge clk) begin
    if (rst) begin
      entry_q <= '0;
      addr_q  <= '0;
      acc_q   <= ACC_LOAD;
      prob_q  <= 1'b0;
      part_q  <= 1'b0;
      amr_q   <= '0;
    end else if (req_valid && req_ready) begin
      entry_q <= req_entry;
      addr_q  <= req_addr;
      acc_q   <= req_acc;
      prob_q  <= req_prob;
      part_q  <= req_part;
      amr_q   <= req_amr;
    end
  end

  // sequencing and registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      done     <= 1'b0;
      fault    <= 1'b0;
      cause    <= '0;
      grant    <= '0;
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_data  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          fault <= ev_fault;
          cause <= ev_cause;
          grant <= ev_grant;
          if (!ev_fault && ev_changed) begin
            wb_valid <= 1'b1;
            wb_addr  <= addr_q;
            wb_data  <= ev_upd;
            state_q  <= ST_WB;
          end else begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_WB: begin
          if (wb_ready) begin
            wb_valid <= 1'b0;
            done     <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/perm_rc_unit_chk.sv
module perm_rc_unit_chk
  import perm_rc_pkg::*;
#(
  parameter int ENTRY_W = 64,
  parameter int ADDR_W  = 48,
  parameter int CAUSE_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic [1:0]         req_acc,
  input logic               done,
  input logic               fault,
  input logic [CAUSE_W-1:0] cause,
  input logic [2:0]         grant,
  input logic               wb_valid,
  input logic               wb_ready,
  input logic [ADDR_W-1:0]  wb_addr,
  input logic [ENTRY_W-1:0] wb_data
);

  logic last_store;

  always_ff @(posedge clk) begin
    if (rst) last_store <= 1'b0;
    else if (req_valid && req_ready) last_store <= (req_acc == ACC_STORE);
  end

  AST_WB_REF_SET: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> wb_data[EB_REF]); // R6

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_data) && $stable(wb_addr)); // R10

  AST_DONE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    done |-> !wb_valid); // R10

  AST_FAULT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    done && fault |-> grant == 3'b000); // R5

  AST_NOSTORE_NO_W: assert property (@(posedge clk) disable iff (rst)
    done && !last_store |-> !grant[PB_WR]); // R7

  AST_STORE_FLAG: assert property (@(posedge clk) disable iff (rst)
    done && fault && last_store |-> cause[CB_STORE]); // R9

  AST_NONSTORE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    done && !last_store |-> !cause[CB_STORE]); // R9

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready); // R11

endmodule

bind perm_rc_unit perm_rc_unit_chk #(
  .ENTRY_W(ENTRY_W), .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_acc(req_acc), .done(done), .fault(fault), .cause(cause),
  .grant(grant), .wb_valid(wb_valid), .wb_ready(wb_ready),
  .wb_addr(wb_addr), .wb_data(wb_data)
);

// File: tb/perm_rc_unit_tb.sv
module perm_rc_unit_tb;

  localparam int EW = 64;
  localparam int AW = 48;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic          req_ready;
  logic [EW-1:0] req_entry;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_acc;
  logic          req_prob;
  logic          req_part;
  logic [2:0]    req_amr;
  logic          done;
  logic          fault;
  logic [CW-1:0] cause;
  logic [2:0]    grant;
  logic          wb_valid;
  logic          wb_ready;
  logic [AW-1:0] wb_addr;
  logic [EW-1:0] wb_data;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  perm_rc_unit #(.ENTRY_W(EW), .ADDR_W(AW), .CAUSE_W(CW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_entry(req_entry), .req_addr(req_addr), .req_acc(req_acc),
    .req_prob(req_prob), .req_part(req_part), .req_amr(req_amr),
    .done(done), .fault(fault), .cause(cause), .grant(grant),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  localparam logic [CW-1:0] C_GUARD = 32'h1000_0000;
  localparam logic [CW-1:0] C_PROT  = 32'h0800_0000;
  localparam logic [CW-1:0] C_STORE = 32'h0200_0000;

  // entry builder: perms {r,w,x}, priv, att, chg, ref
  function automatic logic [EW-1:0] mk(input logic [2:0] p, input logic pv,
                                       input logic [1:0] att, input logic c, input logic r);
    logic [EW-1:0] e;
    e = 64'hABCD_0000_0000_0000;
    e[2:0] = p; e[3] = pv; e[5:4] = att; e[7] = c; e[8] = r;
    return e;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // observed results of the last request
  logic          o_fault;
  logic [CW-1:0] o_cause;
  logic [2:0]    o_grant;
  logic          o_wb;
  logic [EW-1:0] o_wdata;
  logic [AW-1:0] o_waddr;
  int            o_cyc;

  task automatic run(input logic [EW-1:0] e, input logic [AW-1:0] a, input logic [1:0] acc,
                     input logic pr, input logic pt, input logic [2:0] amr, input int lat);
    int wait_n;
    @(negedge clk);
    req_entry = e; req_addr = a; req_acc = acc; req_prob = pr; req_part = pt; req_amr = amr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    o_wb = 1'b0; o_cyc = 0; wait_n = 0;
    while (1) begin
      @(negedge clk);
      o_cyc++;
      if (wb_ready) begin
        o_wb = 1'b1;
        wb_ready = 1'b0;
      end
      if (wb_valid) begin
        o_wdata = wb_data;
        o_waddr = wb_addr;
        if (wait_n >= lat) wb_ready = 1'b1;
        else wait_n++;
      end
      if (done) break;
      if (o_cyc > 40) begin
        chk(1'b0, "R10 timeout waiting for done", 64'(o_cyc), 64'd0);
        break;
      end
    end
    o_fault = fault; o_cause = cause; o_grant = grant;
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R11 ready after reset", 64'(req_ready), 64'd1);
    chk(done == 1'b0 && wb_valid == 1'b0, "R11 idle outputs after reset", {62'd0, done, wb_valid}, 64'd0);
  endtask

  task automatic t_load_ok();
    logic [EW-1:0] e;
    e = mk(3'b111, 1'b0, 2'b00, 1'b0, 1'b0);
    run(e, 48'h0000_1234_5678, 2'b00, 1'b0, 1'b0, 3'b111, 0);
    chk(!o_fault && o_cause == 0, "R5 load allowed", {31'd0, o_fault, o_cause}, 64'd0);
    chk(o_grant == 3'b101, "R7 load drops write", 64'(o_grant), 64'h5);
    chk(o_wb && o_wdata == (e | 64'h100), "R6 ref bit only on load", o_wdata, e | 64'h100);
    chk(o_waddr == 48'h0000_1234_5678, "R8 write-back address", 64'(o_waddr), 64'h12345678);
    chk(o_cyc == 2, "R10 done one cycle after handshake", 64'(o_cyc), 64'd2);
  endtask

  task automatic t_store_ok_stall();
    logic [EW-1:0] e;
    e = mk(3'b111, 1'b0, 2'b00, 1'b0, 1'b0);
    run(e, 48'h0000_0000_0AB8, 2'b01, 1'b0, 1'b0, 3'b111, 3);
    chk(o_grant == 3'b111 && !o_fault, "R7 store keeps write", 64'(o_grant), 64'h7);
    chk(o_wb && o_wdata == (e | 64'h180), "R6 ref and chg on store", o_wdata, e | 64'h180);
    chk(o_cyc == 5, "R10 done after stalled write-back", 64'(o_cyc), 64'd5);
  endtask

  task automatic t_no_change();
    logic [EW-1:0] e;
    e = mk(3'b100, 1'b0, 2'b00, 1'b0, 1'b1);
    run(e, 48'h10, 2'b00, 1'b0, 1'b0, 3'b111, 0);
    chk(!o_wb, "R8 no write-back when unchanged", 64'(o_wb), 64'd0);
    chk(o_cyc == 1 && o_grant == 3'b100, "R10 done two cycles after accept", 64'(o_cyc), 64'd1);
    e = mk(3'b010, 1'b0, 2'b00, 1'b1, 1'b1);
    run(e, 48'h18, 2'b01, 1'b0, 1'b0, 3'b111, 0);
    chk(!o_wb && o_grant == 3'b010, "R8 store on already changed page", {60'd0, o_wb, o_grant}, 64'h2);
  endtask

  task automatic t_io_guard();
    run(mk(3'b111, 1'b0, 2'b10, 1'b0, 1'b0), 48'h20, 2'b10, 1'b0, 1'b0, 3'b111, 0);
    chk(o_fault && o_cause == C_GUARD, "R1 fetch from I/O page", 64'(o_cause), 64'(C_GUARD));
    chk(!o_wb && o_grant == 0, "R1 no grant no write-back", {60'd0, o_wb, o_grant}, 64'd0);
    run(mk(3'b111, 1'b0, 2'b10, 1'b0, 1'b0), 48'h28, 2'b00, 1'b0, 1'b0, 3'b111, 0);
    chk(!o_fault && o_wb, "R1 load from I/O page allowed", {62'd0, o_fault, o_wb}, 64'd1);
  endtask

  task automatic t_priv_problem();
    run(mk(3'b111, 1'b1, 2'b00, 1'b0, 1'b0), 48'h30, 2'b00, 1'b1, 1'b0, 3'b111, 0);
    chk(o_fault && o_cause == C_PROT && o_grant == 0, "R2 priv page in problem state", 64'(o_cause), 64'(C_PROT));
    chk(!o_wb, "R2 no write-back on fault", 64'(o_wb), 64'd0);
    run(mk(3'b111, 1'b1, 2'b00, 1'b0, 1'b1), 48'h38, 2'b00, 1'b1, 1'b1, 3'b000, 0);
    chk(!o_fault && o_grant == 3'b101, "R4 partition scope ignores priv and amr", 64'(o_grant), 64'h5);
  endtask

  task automatic t_amr();
    run(mk(3'b111, 1'b0, 2'b00, 1'b0, 1'b1), 48'h40, 2'b01, 1'b0, 1'b0, 3'b101, 0);
    chk(o_fault && o_cause == (C_PROT | C_STORE), "R9 store denied by amr", 64'(o_cause), 64'(C_PROT | C_STORE));
    run(mk(3'b111, 1'b0, 2'b00, 1'b0, 1'b1), 48'h48, 2'b10, 1'b0, 1'b0, 3'b110, 0);
    chk(o_fault && o_cause == C_PROT, "R3 amr removes execute", 64'(o_cause), 64'(C_PROT));
    run(mk(3'b111, 1'b0, 2'b00, 1'b0, 1'b1), 48'h50, 2'b10, 1'b0, 1'b0, 3'b001, 0);
    chk(!o_fault && o_grant == 3'b001, "R3 amr AND in supervisor", 64'(o_grant), 64'h1);
    run(mk(3'b111, 1'b1, 2'b00, 1'b0, 1'b1), 48'h58, 2'b00, 1'b0, 1'b0, 3'b000, 0);
    chk(!o_fault && o_grant == 3'b101, "R4 priv page supervisor ignores amr", 64'(o_grant), 64'h5);
    run(mk(3'b110, 1'b0, 2'b00, 1'b0, 1'b1), 48'h60, 2'b11, 1'b1, 1'b0, 3'b000, 0);
    chk(!o_fault && o_grant == 3'b100, "R4 problem state ignores amr", 64'(o_grant), 64'h4);
  endtask

  task automatic t_prot();
    run(mk(3'b110, 1'b0, 2'b00, 1'b0, 1'b0), 48'h68, 2'b10, 1'b0, 1'b1, 3'b111, 0);
    chk(o_fault && o_cause == C_PROT && !o_wb, "R5 fetch without execute", 64'(o_cause), 64'(C_PROT));
    run(mk(3'b011, 1'b0, 2'b00, 1'b0, 1'b0), 48'h70, 2'b00, 1'b0, 1'b1, 3'b111, 0);
    chk(o_fault && o_cause == C_PROT && o_grant == 0, "R5 load without read", 64'(o_cause), 64'(C_PROT));
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; wb_ready = 1'b0;
    req_entry = '0; req_addr = '0; req_acc = '0; req_prob = 1'b0; req_part = 1'b0; req_amr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load_ok();
    t_store_ok_stall();
    t_no_change();
    t_io_guard();
    t_priv_problem();
    t_amr();
    t_prot();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #20000;
    n_run++;
    n_fail++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule